// File: doc/BRIEF.md
# Prescaled 16-bit Timer Counter

This block is a 16-bit up-counter. Software sees it as a low byte and a high byte, and it can load either byte at any time. A 2-bit source field chooses what advances the count. The choices are an instruction-rate pulse that fires once every four system clocks, every system clock, synchronized rising edges of an external pin, or an alternate single-cycle enable supplied by a neighbouring block. The chosen source then passes through a prescaler that divides it by 1, 2, 4 or 8. The counter advances only while the run bit is set and the gate-permit input is high.

When the count wraps from all ones to zero, a sticky overflow flag is set. The flag stays set until software clears it. An interrupt request is the flag qualified by an enable bit. Every part of the block runs in the single system clock domain.

Top module: `prescaled_timer16`

## Requirements
- R1: After reset the count is 0000h, the overflow flag is 0 and the interrupt request is 0.
- R2: While `run_en` is 0, neither the count nor the prescaler advances, whatever the source does.
- R3: Source code 00 gives one qualified pulse every four system clocks. It fires at the 4th, 8th, 12th rising edge after reset is released, and so on, whatever the other settings are.
- R4: Source code 01 gives one qualified pulse on every system clock.
- R5: Source code 10 passes `ext_pin` through a two-flop synchronizer and an edge detector. Each low-to-high change gives exactly one pulse. The count changes at the third rising clock edge that samples `ext_pin` high, and a pin held high adds nothing more.
- R6: Source code 11 gives one pulse for each clock in which `alt_tick` is high.
- R7: Divide code d (0 to 3) makes the counter advance once per 2^d qualified pulses.
- R8: While `gate_ok` is 0, neither the count nor the prescaler advances.
- R9: Writing a byte loads it from `wr_data` on the next edge, and the other byte keeps its value. A write in the same cycle as an increment wins, and the increment is lost.
- R10: A write to either byte clears the hidden prescale count, so the next full group of 2^d pulses starts from zero.
- R11: An increment from FFFFh gives 0000h and sets the overflow flag. The flag stays set until `ovf_clr` is high in a cycle without a new overflow. A new overflow wins over a clear in the same cycle.
- R12: `irq` is high exactly when the overflow flag and `irq_en` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run bit; counting stops while low |
| src_sel | input | 2 | Source: 00 instruction rate, 01 system clock, 10 external pin edges, 11 alternate enable |
| div_sel | input | 2 | Prescale: divide by 2^div_sel |
| gate_ok | input | 1 | Gate permit; counting stops while low |
| ext_pin | input | 1 | External count input, asynchronous |
| alt_tick | input | 1 | Alternate single-cycle enable |
| wr_lo | input | 1 | Load low byte from wr_data |
| wr_hi | input | 1 | Load high byte from wr_data |
| wr_data | input | 8 | Byte to load |
| ovf_clr | input | 1 | Clear the overflow flag |
| irq_en | input | 1 | Interrupt enable |
| cnt_lo | output | 8 | Count, low byte |
| cnt_hi | output | 8 | Count, high byte |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Interrupt request |

## Verification
The bench changes inputs on falling edges. A byte load, an increment on sources 00, 01 or 11, and a flag set or clear all show at the outputs one rising edge later. An external pin rise shows three edges later, and `irq` follows the flag in the same cycle. A cycle model in the bench advances on each rising edge from the same inputs, including the free-running divide-by-four phase. The outputs are compared with it at every falling edge, so each result is checked exactly in the cycle it is due. Directed checks at fixed cycle offsets cover the reset value, the write priority, a wrap together with a clear, and the enable gating.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        SRC_INSTR = 2'b00,
        SRC_SYS   = 2'b01,
        SRC_EXT   = 2'b10,
        SRC_ALT   = 2'b11
    } src_sel_e;

    localparam int DIV_SEL_W = 2;
endpackage

// File: rtl/tmr_tick_src.sv
module tmr_tick_src
    import tmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int IDIV_W      = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src_sel,
    input  logic       ext_pin,
    input  logic       alt_tick,
    output logic       tick
);
    typedef struct packed {
        logic [IDIV_W-1:0]      phase;
        logic [SYNC_STAGES-1:0] sync;
        logic                   last;
    } st_t;

    st_t  st_d, st_q;
    logic instr_tick;
    logic ext_edge;

    always_comb begin
        st_d       = st_q;
        st_d.phase = st_q.phase + 1'b1;
        st_d.sync  = {st_q.sync[SYNC_STAGES-2:0], ext_pin};
        st_d.last  = st_q.sync[SYNC_STAGES-1];
        instr_tick = &st_q.phase;
        ext_edge   = st_q.sync[SYNC_STAGES-1] & ~st_q.last;
        unique case (src_sel_e'(src_sel))
            SRC_INSTR: tick = instr_tick;
            SRC_SYS:   tick = 1'b1;
            SRC_EXT:   tick = ext_edge;
            SRC_ALT:   tick = alt_tick;
            default:   tick = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ext_edge |=> !ext_edge); // R5
    AST_INSTR_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        instr_tick |=> !instr_tick); // R3
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
    import tmr_pkg::*;
#(
    parameter int PRE_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DIV_SEL_W-1:0] div_sel,
    input  logic                 tick_in,
    input  logic                 clr,
    output logic                 term
);
    localparam int MASK_W = PRE_W + 1;

    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } st_t;

    st_t              st_d, st_q;
    logic [MASK_W-1:0] mask_wide;
    logic [PRE_W-1:0]  mask;

    always_comb begin
        mask_wide = (MASK_W'(1) << div_sel) - MASK_W'(1);
        mask      = mask_wide[PRE_W-1:0];
        term      = tick_in & (st_q.pre == mask);
        st_d      = st_q;
        if (clr)
            st_d.pre = '0;
        else if (term)
            st_d.pre = '0;
        else if (tick_in)
            st_d.pre = st_q.pre + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_PRE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.pre == '0)); // R10
    AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_in && !clr) |=> $stable(st_q.pre)); // R8
endmodule

// File: rtl/tmr_count16.sv
module tmr_count16 #(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               inc,
    input  logic               wr_lo,
    input  logic               wr_hi,
    input  logic [CNT_W/2-1:0] wr_data,
    input  logic               ovf_clr,
    output logic [CNT_W-1:0]   cnt,
    output logic               ovf
);
    localparam int HALF_W = CNT_W / 2;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } st_t;

    st_t  st_d, st_q;
    logic any_wr;
    logic wrap;

    always_comb begin
        st_d   = st_q;
        any_wr = wr_lo | wr_hi;
        wrap   = inc & ~any_wr & (&st_q.cnt);
        if (any_wr) begin
            if (wr_lo) st_d.cnt[HALF_W-1:0]     = wr_data;
            if (wr_hi) st_d.cnt[CNT_W-1:HALF_W] = wr_data;
        end else if (inc) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        if (wrap)
            st_d.ovf = 1'b1;
        else if (ovf_clr)
            st_d.ovf = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign ovf = st_q.ovf;

    AST_LOAD_LO: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo |=> (cnt[HALF_W-1:0] == $past(wr_data))); // R9
    AST_KEEP_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !wr_hi) |=> (cnt[CNT_W-1:HALF_W] == $past(cnt[CNT_W-1:HALF_W]))); // R9
    AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !wr_lo && !wr_hi && (&cnt)) |=> (ovf && cnt == '0)); // R11
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !ovf_clr) |=> ovf); // R11
endmodule

// File: rtl/prescaled_timer16.sv
module prescaled_timer16
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int PRE_W       = 3,
    parameter int SYNC_STAGES = 2,
    parameter int IDIV_W      = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        run_en,
    input  logic [1:0]  src_sel,
    input  logic [1:0]  div_sel,
    input  logic        gate_ok,
    input  logic        ext_pin,
    input  logic        alt_tick,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [7:0]  wr_data,
    input  logic        ovf_clr,
    input  logic        irq_en,
    output logic [7:0]  cnt_lo,
    output logic [7:0]  cnt_hi,
    output logic        ovf_flag,
    output logic        irq
);
    localparam int HALF_W = CNT_W / 2;

    logic             src_tick;
    logic             qual_tick;
    logic             pre_term;
    logic             any_wr;
    logic [CNT_W-1:0] cnt;
    logic             ovf;

    tmr_tick_src #(.SYNC_STAGES(SYNC_STAGES), .IDIV_W(IDIV_W)) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_sel  (src_sel),
        .ext_pin  (ext_pin),
        .alt_tick (alt_tick),
        .tick     (src_tick)
    );

    always_comb begin
        qual_tick = src_tick & run_en & gate_ok;
        any_wr    = wr_lo | wr_hi;
    end

    tmr_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .div_sel (div_sel),
        .tick_in (qual_tick),
        .clr     (any_wr),
        .term    (pre_term)
    );

    tmr_count16 #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (pre_term),
        .wr_lo   (wr_lo),
        .wr_hi   (wr_hi),
        .wr_data (wr_data),
        .ovf_clr (ovf_clr),
        .cnt     (cnt),
        .ovf     (ovf)
    );

    assign cnt_lo   = cnt[HALF_W-1:0];
    assign cnt_hi   = cnt[CNT_W-1:HALF_W];
    assign ovf_flag = ovf;
    assign irq      = ovf & irq_en;

    AST_HALT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !any_wr) |=> $stable(cnt)); // R2
    AST_HALT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_ok && !any_wr) |=> $stable(cnt)); // R8
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq); // R12
endmodule

// File: tb/sim_prescaled_timer16.sv
module sim_prescaled_timer16;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0, gate_ok = 1'b1, ext_pin = 1'b0, alt_tick = 1'b0;
    logic [1:0] src_sel = 2'b01, div_sel = 2'b00;
    logic       wr_lo = 1'b0, wr_hi = 1'b0, ovf_clr = 1'b0, irq_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] cnt_lo, cnt_hi;
    logic       ovf_flag, irq;

    int    checks = 0;
    int    errors = 0;
    bit    cmp_on = 1'b0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    prescaled_timer16 u0 (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .src_sel(src_sel),
        .div_sel(div_sel), .gate_ok(gate_ok), .ext_pin(ext_pin),
        .alt_tick(alt_tick), .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data),
        .ovf_clr(ovf_clr), .irq_en(irq_en), .cnt_lo(cnt_lo), .cnt_hi(cnt_hi),
        .ovf_flag(ovf_flag), .irq(irq)
    );

    // Reference cycle model built from the requirements
    logic [1:0]  m_phase;
    logic        m_s1, m_s2, m_s3;
    logic [2:0]  m_pre;
    logic [15:0] m_cnt;
    logic        m_ovf;

    function automatic logic [2:0] div_mask(input logic [1:0] d);
        case (d)
            2'd0: return 3'd0;
            2'd1: return 3'd1;
            2'd2: return 3'd3;
            default: return 3'd7;
        endcase
    endfunction

    function automatic logic src_pulse(input logic [1:0] s, input logic [1:0] ph,
                                       input logic s2, input logic s3, input logic alt);
        case (s)
            2'b00: return ph == 2'd3;      // R3
            2'b01: return 1'b1;            // R4
            2'b10: return s2 && !s3;       // R5
            default: return alt;           // R6
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase <= 2'd0; m_s1 <= 1'b0; m_s2 <= 1'b0; m_s3 <= 1'b0;
            m_pre <= 3'd0; m_cnt <= 16'h0; m_ovf <= 1'b0;
        end else begin
            logic q, term, wr;
            q    = run_en && gate_ok && src_pulse(src_sel, m_phase, m_s2, m_s3, alt_tick);
            term = q && (m_pre == div_mask(div_sel));
            wr   = wr_lo || wr_hi;
            m_phase <= m_phase + 2'd1;
            m_s1 <= ext_pin; m_s2 <= m_s1; m_s3 <= m_s2;
            if (wr || term) m_pre <= 3'd0;
            else if (q)     m_pre <= m_pre + 3'd1;
            if (wr) begin
                if (wr_lo) m_cnt[7:0]  <= wr_data;
                if (wr_hi) m_cnt[15:8] <= wr_data;
            end else if (term) m_cnt <= m_cnt + 16'd1;
            if (!wr && term && m_cnt == 16'hFFFF) m_ovf <= 1'b1;
            else if (ovf_clr)                     m_ovf <= 1'b0;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && rst_n) begin
            check(cur_req, "count", {cnt_hi, cnt_lo}, m_cnt);
            check("R11", "ovf_flag", ovf_flag, m_ovf);
            check("R12", "irq", irq, m_ovf & irq_en);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_bytes(input logic lo, input logic hi, input logic [7:0] d);
        wr_lo = lo; wr_hi = hi; wr_data = d;
        step(1);
        wr_lo = 1'b0; wr_hi = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        check("R1", "count", {cnt_hi, cnt_lo}, 0);
        check("R1", "ovf_flag", ovf_flag, 0);
        check("R1", "irq", irq, 0);
        cmp_on = 1'b1;

        // R2: run bit low holds the count on a busy source
        cur_req = "R2"; run_en = 1'b0; src_sel = 2'b01;
        step(20);
        check("R2", "count held", {cnt_hi, cnt_lo}, 0);

        // R4: every system clock
        cur_req = "R4"; run_en = 1'b1;
        step(10);
        check("R4", "count after 10", {cnt_hi, cnt_lo}, 10);

        // R3: instruction rate
        cur_req = "R3"; src_sel = 2'b00;
        step(40);

        // R5: external edges, slow and held levels
        cur_req = "R5"; src_sel = 2'b10;
        for (int i = 0; i < 30; i++) begin
            ext_pin = ~ext_pin;
            step(1 + ($urandom % 6));
        end

        // R6: alternate enable
        cur_req = "R6"; src_sel = 2'b11;
        for (int i = 0; i < 40; i++) begin
            alt_tick = 1'($urandom);
            step(1);
        end
        alt_tick = 1'b0;

        // R7: each divide code
        cur_req = "R7"; src_sel = 2'b01;
        for (int d = 0; d < 4; d++) begin
            div_sel = 2'(d);
            step(40);
        end

        // R8: gate permit
        cur_req = "R8"; div_sel = 2'd1;
        for (int i = 0; i < 60; i++) begin
            gate_ok = 1'($urandom);
            step(1);
        end
        gate_ok = 1'b1;

        // R9: write wins over increment, other byte kept
        cur_req = "R9"; div_sel = 2'd0;
        write_bytes(1'b0, 1'b1, 8'hA5);
        write_bytes(1'b1, 1'b0, 8'h3C);
        check("R9", "low byte loaded", cnt_lo, 8'h3C);
        check("R9", "high byte kept", cnt_hi, 8'hA5);

        // R10: write restarts the prescale group
        cur_req = "R10"; div_sel = 2'd3;
        step(5);
        write_bytes(1'b1, 1'b0, 8'h00);
        step(7);
        check("R10", "no step before 8 pulses", cnt_lo, 8'h00);
        step(1);
        check("R10", "step at 8th pulse", cnt_lo, 8'h01);

        // R11: wrap together with clear, then clear alone
        cur_req = "R11"; run_en = 1'b0; div_sel = 2'd0;
        write_bytes(1'b1, 1'b1, 8'hFF);
        run_en = 1'b1; ovf_clr = 1'b1;
        step(1);
        run_en = 1'b0; ovf_clr = 1'b0;
        check("R11", "flag set over clear", ovf_flag, 1);
        check("R11", "wrapped to zero", {cnt_hi, cnt_lo}, 0);
        step(5);
        check("R11", "flag sticky", ovf_flag, 1);
        ovf_clr = 1'b1; step(1); ovf_clr = 1'b0;
        check("R11", "flag cleared", ovf_flag, 0);

        // R12: interrupt gating
        cur_req = "R12";
        write_bytes(1'b1, 1'b1, 8'hFF);
        run_en = 1'b1; step(1); run_en = 1'b0;
        check("R12", "irq masked", irq, 0);
        irq_en = 1'b1;
        #1 check("R12", "irq raised", irq, 1);
        step(1);

        // Mixed random traffic
        cur_req = "R7";
        for (int i = 0; i < 4000; i++) begin
            run_en   = ($urandom % 8) != 0;
            gate_ok  = ($urandom % 6) != 0;
            src_sel  = 2'($urandom);
            if (($urandom % 32) == 0) div_sel = 2'($urandom);
            ext_pin  = (($urandom % 3) == 0) ? ~ext_pin : ext_pin;
            alt_tick = 1'($urandom);
            wr_lo    = ($urandom % 40) == 0;
            wr_hi    = ($urandom % 40) == 0;
            wr_data  = (($urandom % 2) == 0) ? 8'hFF : 8'($urandom);
            ovf_clr  = ($urandom % 25) == 0;
            irq_en   = 1'($urandom);
            step(1);
        end
        cmp_on = 1'b0;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule